// File: doc/BRIEF.md
# Dual-Port Clock-Compensated Baud Tick Generator

This block gives two serial ports a bit-rate strobe near 230.4 kbaud while the core clock runs at 12, 24 or 48 MHz. A two-bit clock-rate code tells the block the current core frequency. The block picks the matching terminal count by itself, so software does not have to reprogram a divider when the clock changes. Each port also has its own halving input that selects roughly 115.2 kbaud. Each port has its own enable.

Each port owns a free-running counter that emits a one-cycle strobe once per bit period. The serial shifter consumes this strobe downstream. If a port's clock-rate code or halving bit changes, that port's counter restarts at once, so the next period uses the new count and no stretched period appears. The asynchronous reset input is released through an internal two-stage synchronizer.

Top module: `dual_baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, every `baud_tick` bit is 0, even if the port enables are high.
- R2: `core_rate` encodes the core clock: 2'b00 = 12 MHz with a terminal count of 52 cycles, 2'b01 = 24 MHz with 104 cycles, 2'b10 = 48 MHz with 208 cycles, and 2'b11 behaves exactly as 2'b10.
- R3: When a port's `half_rate` bit is 1, that port's terminal count is twice the R2 value (104, 208 or 416).
- R4: With a port enabled and its settings unchanged, consecutive ticks on that port are exactly one terminal count of core cycles apart.
- R5: Every tick is high for exactly one core clock cycle.
- R6: A port whose enable is low produces no tick. After its enable is sampled high at some clock edge, its first tick comes exactly one terminal count of cycles after that edge.
- R7: If `core_rate` or a port's `half_rate` is sampled at an edge with a value different from the one sampled at the previous edge, and the port is enabled, that port restarts. Its next tick comes exactly the new terminal count of cycles after that edge, and no tick is given at the restart edge itself.
- R8: The two ports are independent: the enable and halving bit of one port never affect the tick timing of the other.
- R9: The bit rate implied by every steady tick period stays within 1% of 230400 baud, or of 115200 baud when halving is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_rate | input | 2 | Current core clock rate code (see R2) |
| half_rate | input | 2 | Per-port halving select, bit i for port i |
| port_en | input | 2 | Per-port enable, bit i for port i |
| baud_tick | output | 2 | Per-port one-cycle bit-rate strobe |

## Verification
The assertions assume that the enable, halving and rate inputs are synchronous to `clk`, and that the rate code is a legal two-bit value. They also assume that a configuration change is meant to restart the count and is not a glitch. The bench changes these inputs only just after a falling edge, so each new value is settled well before the next rising edge. Random stimulus draws each of them over its full range. Segment lengths vary from a few cycles up to several periods, so restarts arrive both early and late within a period.

// File: rtl/brg_pkg.sv
package brg_pkg;

  // Core clock rate codes; the highest code aliases the fastest rate.
  typedef enum logic [1:0] {
    CORE_12MHZ  = 2'b00,
    CORE_24MHZ  = 2'b01,
    CORE_48MHZ  = 2'b10,
    CORE_48_ALT = 2'b11
  } core_rate_e;

  // Number of doublings of the base terminal count for a rate code.
  function automatic logic [1:0] rate_shift(input logic [1:0] code);
    logic [1:0] sh;
    case (code)
      CORE_12MHZ: sh = 2'd0;
      CORE_24MHZ: sh = 2'd1;
      default:    sh = 2'd2;
    endcase
    return sh;
  endfunction

endpackage

// File: rtl/brg_reset_sync.sv
module brg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/brg_period_sel.sv
module brg_period_sel
  import brg_pkg::*;
#(
  parameter int BASE_TC = 52,
  parameter int CNT_W   = 9
) (
  input  logic [1:0]       rate_code,
  input  logic             half_sel,
  output logic [CNT_W-1:0] term_cnt
);
  logic [2:0] total_shift;

  always_comb begin
    total_shift = {1'b0, rate_shift(rate_code)} + {2'b00, half_sel};
    term_cnt    = CNT_W'(BASE_TC) << total_shift;
  end
endmodule

// File: rtl/brg_tick_counter.sv
module brg_tick_counter #(
  parameter int BASE_TC = 52,
  parameter int CNT_W   = 9,
  parameter int CFG_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CFG_W-1:0] cfg,
  input  logic [CNT_W-1:0] term_cnt,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CFG_W-1:0] cfg_q;
  logic             en_q;
  logic             tick_q, tick_d;
  logic             restart, at_end, cnt_ce;

  // Next-state logic
  always_comb begin
    restart = en && (!en_q || (cfg != cfg_q));
    at_end  = (cnt_q == (term_cnt - 1'b1));
    cnt_ce  = 1'b1;
    if (!en || restart || at_end) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
    // An idle counter already at zero needs no write.
    if (!en && (cnt_q == '0)) cnt_ce = 1'b0;
    tick_d = en && !restart && at_end;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cfg_q  <= '0;
      en_q   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      cfg_q  <= cfg;
      en_q   <= en;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R6: a tick only follows an edge where the port was enabled
  a_r6_tick_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(en));

  // R6: a disabled port is idle and cleared on the next cycle
  a_r6_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0) && !tick_q);

  // R5: strobes never last two cycles
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  // R4: with steady settings the count stays below the terminal count
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == cfg_q) |-> (cnt_q < term_cnt));

  // R2 / R3: the selected terminal count is one of the legal values
  a_r3_tc_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (term_cnt == CNT_W'(BASE_TC))   || (term_cnt == CNT_W'(BASE_TC*2)) ||
    (term_cnt == CNT_W'(BASE_TC*4)) || (term_cnt == CNT_W'(BASE_TC*8)));
endmodule

// File: rtl/dual_baud_tick_gen.sv
module dual_baud_tick_gen #(
  parameter int NUM_PORTS   = 2,
  parameter int BASE_TC     = 52,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           core_rate,
  input  logic [NUM_PORTS-1:0] half_rate,
  input  logic [NUM_PORTS-1:0] port_en,
  output logic [NUM_PORTS-1:0] baud_tick
);
  // Largest count: fastest clock (x4) with halving (x2).
  localparam int MAX_TC = BASE_TC * 8;
  localparam int CNT_W  = $clog2(MAX_TC + 1);
  localparam int CFG_W  = 3;

  logic srst_n;

  brg_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [CNT_W-1:0] term_cnt;

    brg_period_sel #(.BASE_TC(BASE_TC), .CNT_W(CNT_W)) u_sel (
      .rate_code (core_rate),
      .half_sel  (half_rate[p]),
      .term_cnt  (term_cnt)
    );

    brg_tick_counter #(.BASE_TC(BASE_TC), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_cnt (
      .clk      (clk),
      .rst_n    (srst_n),
      .en       (port_en[p]),
      .cfg      ({core_rate, half_rate[p]}),
      .term_cnt (term_cnt),
      .tick     (baud_tick[p])
    );
  end

  // R1: no strobe while the external reset is asserted
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (baud_tick == '0));
endmodule

// File: tb/dual_baud_tick_gen_tb.sv
`timescale 1ns/1ps
module dual_baud_tick_gen_tb;
  logic       clk;
  logic       rst_n;
  logic [1:0] core_rate;
  logic [1:0] half_rate;
  logic [1:0] port_en;
  logic [1:0] baud_tick;

  int errors = 0;
  int checks = 0;
  int cycle  = 0;
  bit model_on = 0;
  bit done = 0;

  int       nxt [2];
  int       last_tick [2];
  bit       last_valid [2];
  bit       prev_en [2];
  bit [2:0] prev_cfg [2];
  bit       prev_tick [2];

  dual_baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .core_rate(core_rate),
    .half_rate(half_rate), .port_en(port_en), .baud_tick(baud_tick)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cycle++;

  function automatic int exp_tc(input logic [1:0] r, input logic h);
    int b;
    case (r)
      2'b00: b = 52;
      2'b01: b = 104;
      default: b = 208;
    endcase
    return h ? 2*b : b;
  endfunction

  function automatic int core_mhz(input logic [1:0] r);
    case (r)
      2'b00: return 12;
      2'b01: return 24;
      default: return 48;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cycle, act, expv);
    end
  endtask

  // Reference model, evaluated between edges
  always @(negedge clk) begin
    if (!rst_n) begin
      check(baud_tick == 2'b00, "R1", baud_tick, 0);
    end else if (model_on) begin
      for (int p = 0; p < 2; p++) begin
        bit       e, rs, ex, act;
        bit [2:0] cf;
        string    tag;
        int       tc;
        e   = port_en[p];
        cf  = {core_rate, half_rate[p]};
        tc  = exp_tc(core_rate, half_rate[p]);
        rs  = e && (!prev_en[p] || cf != prev_cfg[p]);
        ex  = 0;
        tag = (p == 0) ? "R4 port0" : "R8 port1";
        if (!e) begin
          nxt[p] = -1; last_valid[p] = 0; tag = "R6";
        end else if (rs) begin
          nxt[p] = cycle + tc; last_valid[p] = 0;
          tag = prev_en[p] ? "R7" : "R6";
        end else if (cycle == nxt[p]) begin
          ex = 1; nxt[p] = cycle + tc;
          if (half_rate[p]) tag = "R3";
        end
        act = baud_tick[p];
        check(act == ex, tag, act, ex);
        if (act && prev_tick[p]) check(0, "R5", 2, 1);
        if (act && ex) begin
          if (last_valid[p]) begin
            int per, target, baud, diff;
            per    = cycle - last_tick[p];
            check(per == tc, "R2", per, tc);
            target = half_rate[p] ? 115200 : 230400;
            baud   = (core_mhz(core_rate) * 1000000) / per;
            diff   = (baud > target) ? baud - target : target - baud;
            check(diff * 100 <= target, "R9", baud, target);
          end
          last_tick[p] = cycle; last_valid[p] = 1;
        end
        prev_en[p]   = e;
        prev_cfg[p]  = cf;
        prev_tick[p] = act;
      end
    end
  end

  task automatic seg(input logic [1:0] r, input logic [1:0] h,
                     input logic [1:0] e, input int n);
    @(negedge clk); #1;
    core_rate = r; half_rate = h; port_en = e;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      nxt[p] = -1; last_tick[p] = 0; last_valid[p] = 0;
      prev_en[p] = 0; prev_cfg[p] = 0; prev_tick[p] = 0;
    end
    void'($urandom(32'h5eed1234));
    rst_n = 0; core_rate = 2'b10; half_rate = 2'b00; port_en = 2'b11;
    // R1: enables high during reset must not produce ticks
    repeat (12) @(negedge clk);
    #1 port_en = 2'b00;
    @(negedge clk); #1 rst_n = 1;
    repeat (6) @(negedge clk);
    check(baud_tick == 2'b00, "R1", baud_tick, 0);
    model_on = 1;
    // R2 / R3 / R4 / R9: every rate code with and without halving
    for (int r = 0; r < 4; r++)
      for (int h = 0; h < 2; h++)
        seg(2'(r), {h[0], h[0]}, 2'b11, 3 * exp_tc(2'(r), h[0]) + 7);
    // R8: ports with different halving, one toggling
    seg(2'b01, 2'b10, 2'b11, 700);
    seg(2'b01, 2'b10, 2'b01, 300);
    seg(2'b01, 2'b10, 2'b11, 500);
    // R7: rate change in the middle of a period, both directions
    seg(2'b00, 2'b00, 2'b11, 80);
    seg(2'b10, 2'b00, 2'b11, 100);
    seg(2'b00, 2'b00, 2'b11, 150);
    seg(2'b00, 2'b01, 2'b11, 30);
    // R6: short enable pulses
    seg(2'b00, 2'b00, 2'b00, 20);
    seg(2'b00, 2'b00, 2'b11, 51);
    seg(2'b00, 2'b00, 2'b00, 3);
    seg(2'b00, 2'b00, 2'b11, 120);
    // Random segments
    for (int i = 0; i < 60; i++)
      seg(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
          2'($urandom_range(0, 3)), $urandom_range(1, 900));
    seg(2'b11, 2'b00, 2'b00, 10);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog cycle=%0d actual=0 expected=1", cycle);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule